// File: doc/BRIEF.md
# Trap entry and delegation unit

This block turns a one-cycle trap request into the complete set of architectural updates that trap entry requires. The request carries the cause code, an interrupt flag, the faulting address, the PC of the trapping instruction and the current privilege level. The block also receives the exception and interrupt delegation masks, the supervisor and machine vector bases and the two global interrupt-enable bits. From these it picks the privilege level that will handle the trap and produces the new PC, the new privilege, and the write data and write strobes for the handler level's cause, exception-PC, trap-value and status fields.

The register file that stores these values lies outside the block, and so does the return-from-trap path. The block only computes the values and strobes. Every output is registered and appears on the clock edge after the request. A small two-state controller sequences the update. ST_IDLE is the resting state. The transition IDLE->COMMIT occurs on a request. In ST_COMMIT exactly one of the two write strobes is high. The transition COMMIT->COMMIT occurs on a back-to-back request and the transition COMMIT->IDLE occurs when no request is present.

Privilege encoding used throughout: 0 user, 1 supervisor, 2 hypervisor-reserved, 3 machine.

Top module: `trap_entry_unit`

## Requirements
- R1: The write strobes `s_wr_en` and `m_wr_en` are registered. In the cycle after `trap_req` is high, exactly one of them is high. In the cycle after `trap_req` is low, both are low.
- R2: The written cause has bit XLEN-1 equal to `trap_is_irq`. Bits CODE_W-1:0 hold the (possibly adjusted) code, and all other bits are zero.
- R3: The delegation mask used is `irq_deleg` when `trap_is_irq` is 1 and `exc_deleg` otherwise. The mask is indexed by the CODE_W-bit code, which excludes the interrupt flag.
- R4: The trap goes to supervisor level only when `cur_priv` is 0 or 1 and the selected mask bit is 1. In every other case it goes to machine level.
- R5: Supervisor entry gives the following results. `new_pc` is `s_vec_base` and `new_priv` is 1. `wr_prev_ie` is `s_ie` and `wr_prev_priv` is `cur_priv`. `wr_ie` is 0 and `wr_epc` is `cur_pc`.
- R6: Machine entry gives the following results. `new_pc` is `m_vec_base` and `new_priv` is 3. `wr_prev_ie` is `m_ie` and `wr_prev_priv` is `cur_priv`. `wr_ie` is 0 and `wr_epc` is `cur_pc`.
- R7: `wr_tval` equals `trap_addr` for exception codes 0, 1, 4, 5, 6, 7, 12, 13 and 15. These are the misaligned, access-fault and page-fault codes for fetch, load and store. For every other exception code and for every interrupt, `wr_tval` is zero.
- R8: An exception with code 8 (environment call) is recorded as code 8 + `cur_priv`, which gives 8, 9, 10 or 11. This adjusted code is also the code used for delegation and for R7.
- R9: While reset is held and in the cycle after it is released, both write strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | 1 | One-cycle trap request |
| trap_is_irq | input | 1 | 1 = interrupt, 0 = exception |
| trap_code | input | CODE_W | Cause code without the interrupt flag |
| trap_addr | input | XLEN | Faulting address |
| cur_pc | input | XLEN | PC of the trapping instruction |
| cur_priv | input | 2 | Current privilege level |
| exc_deleg | input | 2**CODE_W | Exception delegation mask |
| irq_deleg | input | 2**CODE_W | Interrupt delegation mask |
| s_vec_base | input | XLEN | Supervisor vector base |
| m_vec_base | input | XLEN | Machine vector base |
| s_ie | input | 1 | Current supervisor interrupt enable |
| m_ie | input | 1 | Current machine interrupt enable |
| new_pc | output | XLEN | PC after trap entry |
| new_priv | output | 2 | Privilege after trap entry |
| s_wr_en | output | 1 | Write strobe for the supervisor trap fields |
| m_wr_en | output | 1 | Write strobe for the machine trap fields |
| wr_cause | output | XLEN | Cause write data |
| wr_epc | output | XLEN | Exception-PC write data |
| wr_tval | output | XLEN | Trap-value write data |
| wr_prev_ie | output | 1 | Previous-enable write data |
| wr_prev_priv | output | 2 | Previous-privilege write data |
| wr_ie | output | 1 | Interrupt-enable write data |

## Verification
Every result of this block is due exactly one rising edge after the request is sampled. This covers the strobes, the new PC and privilege, and the cause, EPC, trap-value and status data. The strobes must also drop one edge after the request is withdrawn. The bench changes inputs on the falling edge and reads the outputs 2 ns after the following rising edge. It inserts idle cycles between requests to observe the strobes dropping, and it also issues requests back to back. It sweeps both trap kinds, all 32 codes, all four privilege levels and four pairs of delegation masks, and it computes each expected value from the requirements.

// File: rtl/trap_pkg.sv
package trap_pkg;

    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;

    localparam int unsigned EXC_ECALL_BASE = 8;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_COMMIT = 1'b1
    } trap_fsm_e;

    // address-bearing exception codes (R7)
    function automatic logic is_addr_fault_code(input int unsigned c);
        return c inside {0, 1, 4, 5, 6, 7, 12, 13, 15};
    endfunction

endpackage

// File: rtl/trap_cause_fmt.sv
module trap_cause_fmt
    import trap_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int CODE_W = 5
) (
    input  logic              is_irq,
    input  logic [CODE_W-1:0] raw_code,
    input  logic [1:0]        priv,
    input  logic [XLEN-1:0]   fault_addr,
    output logic [CODE_W-1:0] eff_code,
    output logic [XLEN-1:0]   cause_word,
    output logic [XLEN-1:0]   tval_word
);
    localparam int NCODES = 1 << CODE_W;
    localparam int PAD_W  = XLEN - 1 - CODE_W;

    logic [NCODES-1:0] fault_map;

    // table of codes that carry an address, one bit per code
    for (genvar g = 0; g < NCODES; g++) begin : g_fault_map
        assign fault_map[g] = is_addr_fault_code(g);
    end

    // environment call adjustment by issuing privilege (R8)
    always_comb begin
        eff_code = raw_code;
        if (!is_irq && raw_code == CODE_W'(EXC_ECALL_BASE)) begin
            eff_code = raw_code + CODE_W'(priv);
        end
    end

    assign cause_word = {is_irq, {PAD_W{1'b0}}, eff_code};
    assign tval_word  = (!is_irq && fault_map[eff_code]) ? fault_addr : '0;

endmodule

// File: rtl/trap_route.sv
module trap_route
    import trap_pkg::*;
#(
    parameter int CODE_W = 5
) (
    input  logic                   is_irq,
    input  logic [CODE_W-1:0]      code,
    input  logic [1:0]             priv,
    input  logic [(1<<CODE_W)-1:0] exc_mask,
    input  logic [(1<<CODE_W)-1:0] irq_mask,
    output logic                   to_super
);
    logic [(1<<CODE_W)-1:0] mask_sel;
    logic                   deleg_bit;
    logic                   priv_ok;

    assign mask_sel  = is_irq ? irq_mask : exc_mask;
    assign deleg_bit = mask_sel[code];
    assign priv_ok   = (priv == PRIV_U) || (priv == PRIV_S);
    assign to_super  = priv_ok && deleg_bit;

endmodule

// File: rtl/trap_status_upd.sv
module trap_status_upd
    import trap_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            to_super,
    input  logic [XLEN-1:0] s_base,
    input  logic [XLEN-1:0] m_base,
    input  logic            s_en,
    input  logic            m_en,
    output logic [XLEN-1:0] tgt_pc,
    output logic [1:0]      tgt_priv,
    output logic            prev_en
);
    always_comb begin
        if (to_super) begin
            tgt_pc   = s_base;
            tgt_priv = PRIV_S;
            prev_en  = s_en;
        end else begin
            tgt_pc   = m_base;
            tgt_priv = PRIV_M;
            prev_en  = m_en;
        end
    end

endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
    import trap_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int CODE_W = 5,
    localparam int DELEG_W = 1 << CODE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trap_req,
    input  logic               trap_is_irq,
    input  logic [CODE_W-1:0]  trap_code,
    input  logic [XLEN-1:0]    trap_addr,
    input  logic [XLEN-1:0]    cur_pc,
    input  logic [1:0]         cur_priv,
    input  logic [DELEG_W-1:0] exc_deleg,
    input  logic [DELEG_W-1:0] irq_deleg,
    input  logic [XLEN-1:0]    s_vec_base,
    input  logic [XLEN-1:0]    m_vec_base,
    input  logic               s_ie,
    input  logic               m_ie,
    output logic [XLEN-1:0]    new_pc,
    output logic [1:0]         new_priv,
    output logic               s_wr_en,
    output logic               m_wr_en,
    output logic [XLEN-1:0]    wr_cause,
    output logic [XLEN-1:0]    wr_epc,
    output logic [XLEN-1:0]    wr_tval,
    output logic               wr_prev_ie,
    output logic [1:0]         wr_prev_priv,
    output logic               wr_ie
);
    trap_fsm_e         state_q, state_d;
    logic [CODE_W-1:0] eff_code;
    logic [XLEN-1:0]   cause_c, tval_c, pc_c;
    logic [1:0]        priv_c;
    logic              to_super, prev_en_c;

    trap_cause_fmt #(.XLEN(XLEN), .CODE_W(CODE_W)) u_fmt (
        .is_irq     (trap_is_irq),
        .raw_code   (trap_code),
        .priv       (cur_priv),
        .fault_addr (trap_addr),
        .eff_code   (eff_code),
        .cause_word (cause_c),
        .tval_word  (tval_c)
    );

    trap_route #(.CODE_W(CODE_W)) u_route (
        .is_irq   (trap_is_irq),
        .code     (eff_code),
        .priv     (cur_priv),
        .exc_mask (exc_deleg),
        .irq_mask (irq_deleg),
        .to_super (to_super)
    );

    trap_status_upd #(.XLEN(XLEN)) u_stat (
        .to_super (to_super),
        .s_base   (s_vec_base),
        .m_base   (m_vec_base),
        .s_en     (s_ie),
        .m_en     (m_ie),
        .tgt_pc   (pc_c),
        .tgt_priv (priv_c),
        .prev_en  (prev_en_c)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (trap_req) state_d = ST_COMMIT;
            ST_COMMIT: state_d = trap_req ? ST_COMMIT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_wr_en      <= 1'b0;
            m_wr_en      <= 1'b0;
            new_pc       <= '0;
            new_priv     <= PRIV_M;
            wr_cause     <= '0;
            wr_epc       <= '0;
            wr_tval      <= '0;
            wr_prev_ie   <= 1'b0;
            wr_prev_priv <= PRIV_U;
            wr_ie        <= 1'b0;
        end else if (state_d == ST_COMMIT) begin
            s_wr_en      <= to_super;
            m_wr_en      <= !to_super;
            new_pc       <= pc_c;
            new_priv     <= priv_c;
            wr_cause     <= cause_c;
            wr_epc       <= cur_pc;
            wr_tval      <= tval_c;
            wr_prev_ie   <= prev_en_c;
            wr_prev_priv <= cur_priv;
            wr_ie        <= 1'b0;
        end else begin
            s_wr_en      <= 1'b0;
            m_wr_en      <= 1'b0;
        end
    end

    a_r1_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({s_wr_en, m_wr_en}));
    a_r1_req_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> (s_wr_en || m_wr_en));
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_req |=> !(s_wr_en || m_wr_en));
    a_r2_irq_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (s_wr_en || m_wr_en) |-> wr_cause[XLEN-1] == $past(trap_is_irq));
    a_r3_no_exc_deleg: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && !trap_is_irq && exc_deleg == '0) |=> m_wr_en);
    a_r4_machine_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && cur_priv == PRIV_M) |=> m_wr_en);
    a_r5_sup_entry: assert property (@(posedge clk) disable iff (!rst_n)
        s_wr_en |-> (new_priv == PRIV_S && !wr_ie && new_pc == $past(s_vec_base)
                     && wr_prev_ie == $past(s_ie)));
    a_r6_mach_entry: assert property (@(posedge clk) disable iff (!rst_n)
        m_wr_en |-> (new_priv == PRIV_M && !wr_ie && new_pc == $past(m_vec_base)
                     && wr_prev_ie == $past(m_ie)));
    a_r7_irq_tval_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && trap_is_irq) |=> wr_tval == '0);
    a_r8_ecall_from_m: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && !trap_is_irq && trap_code == CODE_W'(8) && cur_priv == PRIV_M)
        |=> wr_cause[CODE_W-1:0] == CODE_W'(11));

endmodule

// File: tb/sim_trap_entry_unit.sv
module sim_trap_entry_unit;
    localparam int XLEN   = 32;
    localparam int CODE_W = 5;
    localparam int DW     = 1 << CODE_W;

    logic clk = 1'b0, rst_n = 1'b0;
    logic trap_req = 1'b0, trap_is_irq = 1'b0, s_ie = 1'b0, m_ie = 1'b0;
    logic [CODE_W-1:0] trap_code = '0;
    logic [XLEN-1:0] trap_addr = '0, cur_pc = '0, s_vec_base = '0, m_vec_base = '0;
    logic [1:0] cur_priv = '0;
    logic [DW-1:0] exc_deleg = '0, irq_deleg = '0;
    logic [XLEN-1:0] new_pc, wr_cause, wr_epc, wr_tval;
    logic [1:0] new_priv, wr_prev_priv;
    logic s_wr_en, m_wr_en, wr_prev_ie, wr_ie;

    int n_cmp = 0, n_bad = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #4 clk = ~clk;

    trap_entry_unit #(.XLEN(XLEN), .CODE_W(CODE_W)) u0 (
        .clk, .rst_n, .trap_req, .trap_is_irq, .trap_code, .trap_addr, .cur_pc,
        .cur_priv, .exc_deleg, .irq_deleg, .s_vec_base, .m_vec_base, .s_ie, .m_ie,
        .new_pc, .new_priv, .s_wr_en, .m_wr_en, .wr_cause, .wr_epc, .wr_tval,
        .wr_prev_ie, .wr_prev_priv, .wr_ie
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] lcg(input logic [31:0] s);
        return s * 32'd1664525 + 32'd1013904223;
    endfunction

    function automatic bit fault_code(input int c);
        return (c == 0) || (c == 1) || (c == 4) || (c == 5) || (c == 6) ||
               (c == 7) || (c == 12) || (c == 13) || (c == 15);
    endfunction

    initial begin : watchdog
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stim
        int vec = 0;
        repeat (3) @(posedge clk);
        #2;
        check("R9 s_wr_en in reset", 64'(s_wr_en), 64'd0);
        check("R9 m_wr_en in reset", 64'(m_wr_en), 64'd0);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #2;
        check("R9 strobes after release", 64'({s_wr_en, m_wr_en}), 64'd0);

        for (int pat = 0; pat < 4; pat++) begin
            for (int irq = 0; irq < 2; irq++) begin
                for (int code = 0; code < DW; code++) begin
                    for (int pv = 0; pv < 4; pv++) begin
                        logic [DW-1:0] em, im, msk;
                        int ecode;
                        bit sup;
                        logic [XLEN-1:0] e_cause, e_tval;
                        seed = lcg(seed);
                        case (pat)
                            0: em = '0;
                            1: em = '1;
                            2: em = 32'hAAAA_5555;
                            default: em = seed;
                        endcase
                        im = {em[15:0], em[31:16]} ^ 32'h0F0F_F0F0;
                        @(negedge clk);
                        trap_req    = 1'b1;
                        trap_is_irq = irq[0];
                        trap_code   = CODE_W'(code);
                        cur_priv    = 2'(pv);
                        exc_deleg   = em;
                        irq_deleg   = im;
                        trap_addr   = seed ^ 32'hDEAD_0000;
                        cur_pc      = {seed[15:0], seed[31:16]};
                        s_vec_base  = 32'h8000_1000 + {seed[7:0], 2'b00};
                        m_vec_base  = 32'h8000_2000 + {seed[15:8], 2'b00};
                        s_ie        = seed[3];
                        m_ie        = seed[9];
                        // expected values from the requirements
                        ecode   = (irq == 0 && code == 8) ? 8 + pv : code;
                        msk     = irq ? im : em;
                        sup     = (pv <= 1) && msk[ecode];
                        e_cause = (32'(irq) << 31) | 32'(ecode);
                        e_tval  = (irq == 0 && fault_code(ecode)) ? trap_addr : '0;
                        @(posedge clk); #2;
                        check("R3 R4 s_wr_en", 64'(s_wr_en), 64'(sup));
                        check("R1 R4 m_wr_en", 64'(m_wr_en), 64'(!sup));
                        check("R5 R6 new_pc", 64'(new_pc), 64'(sup ? s_vec_base : m_vec_base));
                        check("R5 R6 new_priv", 64'(new_priv), sup ? 64'd1 : 64'd3);
                        check("R2 R8 wr_cause", 64'(wr_cause), 64'(e_cause));
                        check("R5 R6 wr_epc", 64'(wr_epc), 64'(cur_pc));
                        check("R7 wr_tval", 64'(wr_tval), 64'(e_tval));
                        check("R5 R6 wr_prev_ie", 64'(wr_prev_ie), 64'(sup ? s_ie : m_ie));
                        check("R5 R6 wr_prev_priv", 64'(wr_prev_priv), 64'(pv));
                        check("R5 R6 wr_ie", 64'(wr_ie), 64'd0);
                        vec++;
                        if (vec % 7 == 0) begin
                            @(negedge clk) trap_req = 1'b0;
                            @(posedge clk); #2;
                            check("R1 strobes drop when idle", 64'({s_wr_en, m_wr_en}), 64'd0);
                        end
                    end
                end
            end
        end
        @(negedge clk) trap_req = 1'b0;
        @(posedge clk); #2;
        check("R1 final idle", 64'({s_wr_en, m_wr_en}), 64'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule